// File: doc/BRIEF.md
# Power Rail Sequencer with Protection Latch

This block supervises a multi-output supply from the digital side. An external on/off request sets which switchable output rails are on. The request is already synchronous to the block clock. Overvoltage flags from three monitored rails and overcurrent flags from two monitored rails are also inputs, and they are already synchronized too. The block drives one enable per switchable rail, an enable for the always-on standby rail, and a master enable that lets the primary converter oscillate. Analog sensing, comparators and regulators are outside the block.

The switchable rails are asymmetric in timing. They shut off on the clock edge that sees the request low. They turn on only after the request has stayed high for a programmable delay, about 300 ms by default. This delay is a cycle count derived from the clock frequency and the delay in microseconds. A single cycle of any protection flag shuts down every output, the standby rail included, and sets a latch. The latch does not respond to the flag going away. It clears only when input power is applied again, which is modelled here by the synchronous active-high reset. A sticky two-bit cause register records which kinds of fault were seen.

Top module: `pwr_rail_supervisor`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are low after that edge: `sw_en`, `stby_en`, `osc_en`, `fault_latched` and `fault_cause`.
- R2: With no fault seen since reset, `stby_en` and `osc_en` are high from the first edge after reset release, whatever the level of `on_req`.
- R3: While `on_req` stays high, every bit of `sw_en` rises together exactly ON_DELAY_CYC edges after the first edge that samples `on_req` high. ON_DELAY_CYC = (CLK_FREQ_HZ/1_000_000)*ON_DELAY_US.
- R4: An edge that samples `on_req` low drives all `sw_en` bits low after that same edge.
- R5: A request that drops before the delay expires restarts the count. The next rise of `on_req` again needs the full ON_DELAY_CYC edges.
- R6: A high on any bit of `ov_flag` at one edge, even for one cycle only, makes `osc_en`, `stby_en` and `sw_en` low and `fault_latched` high after that edge.
- R7: A high on any bit of `oc_flag` at one edge, even for one cycle only, has the same effect as R6.
- R8: Once latched, all enables stay low and `fault_latched` stays high whatever `on_req`, `ov_flag` and `oc_flag` do, until a reset.
- R9: `fault_cause` bit 0 is set by any overvoltage and bit 1 by any overcurrent. Each bit is sticky and both kinds accumulate.
- R10: A reset pulse after a latch clears `fault_latched` and `fault_cause`. One edge after release, `stby_en` and `osc_en` are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, stands for input power re-entry |
| on_req | input | 1 | Synchronous request for the switchable rails |
| ov_flag | input | 3 | Overvoltage flags, one per monitored rail |
| oc_flag | input | 2 | Overcurrent flags, one per monitored rail |
| sw_en | output | NUM_SW (4) | Enables of the switchable rails |
| stby_en | output | 1 | Standby rail enable |
| osc_en | output | 1 | Master converter oscillation enable |
| fault_latched | output | 1 | High while the protection latch is set |
| fault_cause | output | 2 | Sticky cause: bit 0 overvoltage, bit 1 overcurrent |

## Verification
Every output comes from one register. Faults, request drops and reset therefore show their effect one edge after they are sampled. The rise of the rail enables comes exactly ON_DELAY_CYC edges after the request is first sampled high. The bench drives and samples only on falling edges and counts rising edges between stimulus and observation. Each check sits at the edge where a result is due: the cycle before a rise for the negative case, and the cycle of the rise itself. A sweep of request pulse lengths across and past the delay window uses the arithmetic rule k >= ON_DELAY_CYC to predict each cycle's enable. A sweep over every protection flag bit checks the one-edge shutdown, the latch's persistence and the cause bits.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;

  // Number of monitored rails for each protection kind.
  localparam int unsigned NUM_OV = 3;
  localparam int unsigned NUM_OC = 2;

  // Sticky fault cause; packed so that ov lands on bit 0.
  typedef struct packed {
    logic oc;
    logic ov;
  } fault_cause_t;

endpackage

// File: rtl/psu_fault_latch.sv
module psu_fault_latch
  import psu_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_OV-1:0]   ov_in,
  input  logic [NUM_OC-1:0]   oc_in,
  output logic                fault_now,
  output logic                latched_q,
  output fault_cause_t        cause_q
);

  logic any_ov;
  logic any_oc;

  assign any_ov    = |ov_in;
  assign any_oc    = |oc_in;
  assign fault_now = any_ov | any_oc;

  // Set-only latch: a flag going low again has no path to clear it.
  always_ff @(posedge clk) begin
    if (rst) begin
      latched_q  <= 1'b0;
      cause_q    <= '0;
    end else begin
      latched_q  <= latched_q  | fault_now;
      cause_q.ov <= cause_q.ov | any_ov;
      cause_q.oc <= cause_q.oc | any_oc;
    end
  end

endmodule

// File: rtl/psu_on_timer.sv
module psu_on_timer #(
  parameter int unsigned DELAY_CYC = 15_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ready
);

  // ready is asserted one count early; the output register adds the last cycle.
  localparam int unsigned LIMIT = (DELAY_CYC > 0) ? DELAY_CYC - 1 : 0;
  localparam int unsigned CW    = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign ready = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/psu_out_stage.sv
module psu_out_stage #(
  parameter int unsigned NUM_SW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              ready,
  input  logic              fault_now,
  input  logic              latched,
  output logic [NUM_SW-1:0] sw_q,
  output logic              stby_q,
  output logic              osc_q
);

  logic kill;

  assign kill = fault_now | latched;

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_q <= 1'b0;
      osc_q  <= 1'b0;
    end else begin
      stby_q <= !kill;
      osc_q  <= !kill;
    end
  end

  for (genvar g = 0; g < NUM_SW; g++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst) begin
        sw_q[g] <= 1'b0;
      end else begin
        sw_q[g] <= req & ready & !kill;
      end
    end
  end

endmodule

// File: rtl/pwr_rail_supervisor.sv
module pwr_rail_supervisor
  import psu_seq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned ON_DELAY_US = 300_000,
  parameter int unsigned NUM_SW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              on_req,
  input  logic [NUM_OV-1:0] ov_flag,
  input  logic [NUM_OC-1:0] oc_flag,
  output logic [NUM_SW-1:0] sw_en,
  output logic              stby_en,
  output logic              osc_en,
  output logic              fault_latched,
  output logic [1:0]        fault_cause
);

  localparam int unsigned ON_DELAY_CYC = (CLK_FREQ_HZ / 1_000_000) * ON_DELAY_US;

  logic         fault_now;
  logic         latched_q;
  fault_cause_t cause_q;
  logic         ready;

  psu_fault_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .ov_in     (ov_flag),
    .oc_in     (oc_flag),
    .fault_now (fault_now),
    .latched_q (latched_q),
    .cause_q   (cause_q)
  );

  psu_on_timer #(
    .DELAY_CYC (ON_DELAY_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .req   (on_req),
    .ready (ready)
  );

  psu_out_stage #(
    .NUM_SW (NUM_SW)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .req       (on_req),
    .ready     (ready),
    .fault_now (fault_now),
    .latched   (latched_q),
    .sw_q      (sw_en),
    .stby_q    (stby_en),
    .osc_q     (osc_en)
  );

  assign fault_latched = latched_q;
  assign fault_cause   = cause_q;

endmodule

// File: rtl/psu_seq_checker.sv
module psu_seq_checker
  import psu_seq_pkg::*;
#(
  parameter int unsigned NUM_SW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              on_req,
  input logic [NUM_OV-1:0] ov_flag,
  input logic [NUM_OC-1:0] oc_flag,
  input logic [NUM_SW-1:0] sw_en,
  input logic              stby_en,
  input logic              osc_en,
  input logic              fault_latched,
  input logic [1:0]        fault_cause
);

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (sw_en == '0 && !stby_en && !osc_en && !fault_latched && fault_cause == 2'b00)); // R1

  AST_SW_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
    (sw_en == '0 || &sw_en)); // R3

  AST_DROP_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    !on_req |=> (sw_en == '0)); // R4

  AST_OV_KILLS: assert property (@(posedge clk) disable iff (rst)
    (|ov_flag) |=> (!osc_en && !stby_en && fault_latched && fault_cause[0])); // R6

  AST_OC_KILLS: assert property (@(posedge clk) disable iff (rst)
    (|oc_flag) |=> (!osc_en && !stby_en && fault_latched && fault_cause[1])); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fault_latched |=> (fault_latched && !osc_en && !stby_en && sw_en == '0)); // R8

  AST_CAUSE_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_cause[0] |=> fault_cause[0]); // R9

  AST_CAUSE_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_cause[1] |=> fault_cause[1]); // R9

endmodule

bind pwr_rail_supervisor psu_seq_checker #(
  .NUM_SW (NUM_SW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .on_req        (on_req),
  .ov_flag       (ov_flag),
  .oc_flag       (oc_flag),
  .sw_en         (sw_en),
  .stby_en       (stby_en),
  .osc_en        (osc_en),
  .fault_latched (fault_latched),
  .fault_cause   (fault_cause)
);

// File: tb/test_pwr_rail_supervisor.sv
module test_pwr_rail_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_HZ    = 1_000_000;
  localparam int DLY_US     = 12;
  localparam int D          = (FREQ_HZ / 1_000_000) * DLY_US;
  localparam int NSW        = 4;
  localparam int WATCHDOG   = 200_000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           on_req = 1'b0;
  logic [2:0]     ov_flag = '0;
  logic [1:0]     oc_flag = '0;
  logic [NSW-1:0] sw_en;
  logic           stby_en;
  logic           osc_en;
  logic           fault_latched;
  logic [1:0]     fault_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_rail_supervisor #(
    .CLK_FREQ_HZ (FREQ_HZ),
    .ON_DELAY_US (DLY_US),
    .NUM_SW      (NSW)
  ) i_pwr_rail_supervisor (
    .clk           (clk),
    .rst           (rst),
    .on_req        (on_req),
    .ov_flag       (ov_flag),
    .oc_flag       (oc_flag),
    .sw_en         (sw_en),
    .stby_en       (stby_en),
    .osc_en        (osc_en),
    .fault_latched (fault_latched),
    .fault_cause   (fault_cause)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Everything low except the latch bit, with the expected cause.
  task automatic chk_latched(input string req, input logic [1:0] cause);
    chk(req, "sw_en", 32'(sw_en), 0);
    chk(req, "stby_en", 32'(stby_en), 0);
    chk(req, "osc_en", 32'(osc_en), 0);
    chk(req, "fault_latched", 32'(fault_latched), 1);
    chk(req, "fault_cause", 32'(fault_cause), 32'(cause));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1);
    chk("R1", "sw_en", 32'(sw_en), 0);
    chk("R1", "stby_en", 32'(stby_en), 0);
    chk("R1", "osc_en", 32'(osc_en), 0);
    chk("R1", "fault_latched", 32'(fault_latched), 0);
    chk("R1", "fault_cause", 32'(fault_cause), 0);
    rst = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    do_reset();
    chk("R2", "stby_en after release", 32'(stby_en), 1);
    chk("R2", "osc_en after release", 32'(osc_en), 1);
    chk("R2", "sw_en idle", 32'(sw_en), 0);

    // R3 R5: sweep request pulse lengths across and past the delay window.
    for (int len = 1; len <= D + 3; len++) begin
      on_req = 1'b1;
      for (int k = 1; k <= len; k++) begin
        tick(1);
        chk((k >= D) ? "R3" : "R5", "sw_en during request",
            32'(sw_en), (k >= D) ? 32'((1 << NSW) - 1) : 0);
        chk("R2", "stby_en with request", 32'(stby_en), 1);
      end
      on_req = 1'b0;
      tick(1);
      chk("R4", "sw_en after drop", 32'(sw_en), 0);
      chk("R2", "osc_en after drop", 32'(osc_en), 1);
      tick(1);
    end

    // R6 R7 R8 R10: single-cycle pulse on every protection flag bit.
    for (int b = 0; b < 5; b++) begin
      logic [1:0] cause;
      cause = (b < 3) ? 2'b01 : 2'b10;
      on_req = 1'b1;
      tick(D);
      chk("R3", "sw_en on before fault", 32'(sw_en), 32'((1 << NSW) - 1));
      if (b < 3) ov_flag[b] = 1'b1; else oc_flag[b-3] = 1'b1;
      tick(1);
      ov_flag = '0;
      oc_flag = '0;
      chk_latched((b < 3) ? "R6" : "R7", cause);
      on_req = 1'b0;
      tick(2);
      chk_latched("R8", cause);
      on_req = 1'b1;
      tick(D + 2);
      chk_latched("R8", cause);
      on_req = 1'b0;
      do_reset();
      chk("R10", "stby_en after reentry", 32'(stby_en), 1);
      chk("R10", "osc_en after reentry", 32'(osc_en), 1);
      chk("R10", "fault_latched after reentry", 32'(fault_latched), 0);
    end

    // R9: fault with request low, then the other kind accumulates.
    ov_flag = 3'b100;
    tick(1);
    ov_flag = '0;
    chk("R9", "cause ov only", 32'(fault_cause), 32'h1);
    chk("R6", "stby_en low with request low", 32'(stby_en), 0);
    tick(3);
    oc_flag = 2'b01;
    tick(1);
    oc_flag = '0;
    chk("R9", "cause accumulated", 32'(fault_cause), 32'h3);
    do_reset();
    ov_flag = 3'b001;
    oc_flag = 2'b10;
    tick(1);
    ov_flag = '0;
    oc_flag = '0;
    chk_latched("R9", 2'b11);
    do_reset();
    chk("R10", "cause cleared", 32'(fault_cause), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule